// File: doc/BRIEF.md
# Transmit Flow-Control Sequencer

This block decides when an Ethernet transmitter may start data frames. Software can ask it to advertise a pause to the link partner. The block then lets the frame already on the wire finish and blocks new data frames. It flags that the stop is complete and tells the datapath to emit one MAC control PAUSE frame, which carries the programmed pause time. When the datapath reports that this frame has ended, the block flags completion, drops the software request and lets data flow again.

Independently, a PAUSE frame received from the partner starts a countdown measured in quanta of 512 bit times, scaled to the link speed. While the countdown runs, data frames are held off and a status bit is visible. A software graceful stop also holds off data. Neither of these holds prevents the block from sending its own PAUSE frame. In half-duplex 10/100 operation, a software bit forces carrier toward the medium to apply backpressure.

The sequencer has four states: IDLE, DRAIN, LAUNCH and WAIT_TX. There are four transitions:
- IDLE→DRAIN when the request bit is set.
- DRAIN→LAUNCH when `tx_busy` is low. This edge raises the stop-complete event.
- LAUNCH→WAIT_TX unconditionally. LAUNCH is the cycle in which the control frame is started.
- WAIT_TX→IDLE on `tx_eof`. This edge raises the frame-sent event and clears the request.

Top module: `tx_flow_ctrl`

## Requirements
- R1: In the cycle after `pause_set` pulses, `pause_req` reads 1 and `data_allow` reads 0. While `tx_busy` stays high, no control frame starts and no stop-complete event is raised.
- R2: Once `tx_busy` is low with a request pending, event bit 0 (stop complete) of `evt_flags` becomes 1.
- R3: The control frame is commanded by a single-cycle `ctrl_start` pulse. It occurs after the stop-complete event, and `ctrl_pause_time` equals `ptv_value` during that pulse.
- R4: A `tx_eof` pulse after the control frame started does three things in the following cycle: event bit 1 (frame sent) is set, `pause_req` returns to 0, and `data_allow` returns to 1 if nothing else holds data.
- R5: A control frame is still commanded while a received pause is active, and also while `gts_req` is high.
- R6: A received PAUSE (`rx_pause_valid` with nonzero `rx_pause_quanta`) sets `rx_paused` and holds `data_allow` at 0 for exactly quanta×Q cycles. Q is 64 for `speed_sel`=2'b10 or 2'b11 (1000 Mb/s), 640 for 2'b01 (100 Mb/s) and 6400 for 2'b00 (10 Mb/s), with the default parameter. `rx_paused` then clears by itself.
- R7: `carrier_force` is 1 exactly when `bp_enable` and `half_duplex` are both 1 and the speed is not 1000 Mb/s. It stays on until `bp_enable` is cleared.
- R8: A received PAUSE during an active pause restarts the countdown with the new quanta.
- R9: A received PAUSE with zero quanta clears `rx_paused` in the next cycle.
- R10: Event bits are sticky and are cleared by writing 1 to the matching bit of `evt_clr`. A clear leaves the other bit untouched.
- R11: While `gts_req` is 1, `data_allow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pause_set | input | 1 | Software write of 1 to the pause request bit |
| ptv_value | input | 16 | Pause time placed in the outgoing control frame |
| rx_pause_valid | input | 1 | Received PAUSE frame decoded |
| rx_pause_quanta | input | 16 | Quanta carried by the received PAUSE |
| speed_sel | input | 2 | 00 = 10, 01 = 100, 1x = 1000 Mb/s |
| half_duplex | input | 1 | Link is half duplex |
| bp_enable | input | 1 | Software backpressure bit |
| gts_req | input | 1 | Software graceful stop of data |
| tx_busy | input | 1 | A data frame is in flight in the datapath |
| tx_eof | input | 1 | Datapath finished the current frame |
| evt_clr | input | 2 | Write-1-to-clear for the event bits |
| data_allow | output | 1 | Datapath may start a new data frame |
| ctrl_start | output | 1 | Start a MAC control PAUSE frame |
| ctrl_pause_time | output | 16 | Pause time for the control frame |
| pause_req | output | 1 | Current software pause request bit |
| rx_paused | output | 1 | Received pause in force |
| carrier_force | output | 1 | Raise carrier for half-duplex backpressure |
| evt_flags | output | 2 | Sticky events: bit 0 stop complete, bit 1 frame sent |

## Verification
The in-line assertions check several rules on every cycle:
- The stop-complete pulse never coincides with a busy datapath.
- The request bit only falls on a control-frame end.
- A running pause is not cut short while quanta remain.
- Set event bits stick.
- Carrier forcing requires half duplex.
- Control frames never overlap permitted data.

Only the bench scenarios can show three further properties:
- The ordering of stop-complete, control frame and frame-sent events, and the pause time carried.
- The exact pause length per speed, and reload and zero-quanta behaviour.
- Sending a PAUSE under a received pause or a graceful stop.

// File: rtl/flow_pkg.sv
package flow_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_WAIT   = 2'd3
    } fc_state_t;

    localparam int EVT_STOP = 0;
    localparam int EVT_SENT = 1;
    localparam int EVT_N    = 2;

    localparam logic [1:0] SPD_10  = 2'b00;
    localparam logic [1:0] SPD_100 = 2'b01;
endpackage

// File: rtl/pause_tx_fsm.sv
module pause_tx_fsm
    import flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pause_set,
    input  logic tx_busy,
    input  logic tx_eof,
    output logic req_o,
    output logic hold_data,
    output logic ctrl_start,
    output logic stop_pulse,
    output logic sent_pulse
);
    fc_state_t state, nxt;
    logic      req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            req_q <= 1'b0;
        end else begin
            state <= nxt;
            if (pause_set)       req_q <= 1'b1;
            else if (sent_pulse) req_q <= 1'b0;
        end
    end

    always_comb begin
        nxt        = state;
        ctrl_start = 1'b0;
        stop_pulse = 1'b0;
        sent_pulse = 1'b0;
        unique case (state)
            ST_IDLE:   if (req_q) nxt = ST_DRAIN;
            ST_DRAIN:  if (!tx_busy) begin
                           nxt        = ST_LAUNCH;
                           stop_pulse = 1'b1;
                       end
            ST_LAUNCH: begin
                           ctrl_start = 1'b1;
                           nxt        = ST_WAIT;
                       end
            ST_WAIT:   if (tx_eof) begin
                           sent_pulse = 1'b1;
                           nxt        = ST_IDLE;
                       end
            default:   nxt = ST_IDLE;
        endcase
    end

    assign req_o     = req_q;
    assign hold_data = req_q || (state != ST_IDLE);

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !tx_busy);
    // R4
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(tx_eof));
endmodule

// File: rtl/rx_pause_timer.sv
module rx_pause_timer
    import flow_pkg::*;
#(
    parameter int QW      = 16,
    parameter int GIG_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] quanta,
    input  logic [1:0]    speed,
    output logic          paused
);
    localparam int CYC100 = GIG_CYC * 10;
    localparam int CYC10  = GIG_CYC * 100;
    localparam int SW     = $clog2(CYC10 + 1);

    logic [QW-1:0] q_cnt;
    logic [SW-1:0] sub_cnt;
    logic [SW-1:0] sub_top;

    always_comb begin
        unique case (speed)
            SPD_10:  sub_top = SW'(CYC10 - 1);
            SPD_100: sub_top = SW'(CYC100 - 1);
            default: sub_top = SW'(GIG_CYC - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paused  <= 1'b0;
            q_cnt   <= '0;
            sub_cnt <= '0;
        end else if (load) begin
            paused  <= (quanta != '0);
            q_cnt   <= quanta;
            sub_cnt <= sub_top;
        end else if (paused) begin
            if (sub_cnt == '0) begin
                if (q_cnt == QW'(1)) paused <= 1'b0;
                q_cnt   <= q_cnt - QW'(1);
                sub_cnt <= sub_top;
            end else begin
                sub_cnt <= sub_cnt - SW'(1);
            end
        end
    end

    // R6
    no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !load && q_cnt > QW'(1)) |=> paused);
endmodule

// File: rtl/evt_sticky.sv
module evt_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end

        // R10
        sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);
    end
endmodule

// File: rtl/tx_flow_ctrl.sv
module tx_flow_ctrl
    import flow_pkg::*;
#(
    parameter int QW      = 16,
    parameter int GIG_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pause_set,
    input  logic [QW-1:0] ptv_value,
    input  logic          rx_pause_valid,
    input  logic [QW-1:0] rx_pause_quanta,
    input  logic [1:0]    speed_sel,
    input  logic          half_duplex,
    input  logic          bp_enable,
    input  logic          gts_req,
    input  logic          tx_busy,
    input  logic          tx_eof,
    input  logic [1:0]    evt_clr,
    output logic          data_allow,
    output logic          ctrl_start,
    output logic [QW-1:0] ctrl_pause_time,
    output logic          pause_req,
    output logic          rx_paused,
    output logic          carrier_force,
    output logic [1:0]    evt_flags
);
    logic             hold_data;
    logic             stop_pulse;
    logic             sent_pulse;
    logic [EVT_N-1:0] evt_set;

    pause_tx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_set  (pause_set),
        .tx_busy    (tx_busy),
        .tx_eof     (tx_eof),
        .req_o      (pause_req),
        .hold_data  (hold_data),
        .ctrl_start (ctrl_start),
        .stop_pulse (stop_pulse),
        .sent_pulse (sent_pulse)
    );

    rx_pause_timer #(.QW(QW), .GIG_CYC(GIG_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rx_pause_valid),
        .quanta (rx_pause_quanta),
        .speed  (speed_sel),
        .paused (rx_paused)
    );

    always_comb begin
        evt_set           = '0;
        evt_set[EVT_STOP] = stop_pulse;
        evt_set[EVT_SENT] = sent_pulse;
    end

    evt_sticky #(.N(EVT_N)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_set),
        .clr   (evt_clr),
        .flags (evt_flags)
    );

    assign ctrl_pause_time = ptv_value;
    assign data_allow      = !hold_data && !rx_paused && !gts_req;
    assign carrier_force   = bp_enable && half_duplex && !speed_sel[1];

    // R7
    bp_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_force |-> (half_duplex && bp_enable));
    // R5
    ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_start |-> !data_allow);
endmodule

// File: tb/test_tx_flow_ctrl.sv
module test_tx_flow_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause_set = 0, rx_pause_valid = 0, half_duplex = 0, bp_enable = 0;
    logic        gts_req = 0, tx_busy = 0, tx_eof = 0;
    logic [15:0] ptv_value = 16'h1234, rx_pause_quanta = 0;
    logic [1:0]  speed_sel = 2'b10, evt_clr = 0;
    logic        data_allow, ctrl_start, pause_req, rx_paused, carrier_force;
    logic [15:0] ctrl_pause_time;
    logic [1:0]  evt_flags;

    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    logic [15:0] exp_ptv = 16'h1234;
    logic [1:0] prev_evt = 0;

    always #2.5 clk = ~clk;

    tx_flow_ctrl i_tx_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .pause_set(pause_set), .ptv_value(ptv_value),
        .rx_pause_valid(rx_pause_valid), .rx_pause_quanta(rx_pause_quanta),
        .speed_sel(speed_sel), .half_duplex(half_duplex), .bp_enable(bp_enable),
        .gts_req(gts_req), .tx_busy(tx_busy), .tx_eof(tx_eof), .evt_clr(evt_clr),
        .data_allow(data_allow), .ctrl_start(ctrl_start),
        .ctrl_pause_time(ctrl_pause_time), .pause_req(pause_req),
        .rx_paused(rx_paused), .carrier_force(carrier_force), .evt_flags(evt_flags)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops expected event codes 1=stop done, 2=control frame, 3=sent
    task automatic observe(input int code);
        int e;
        if (exp_q.size() == 0) begin
            chk(0, "R3 unexpected event", code, 0);
        end else begin
            e = exp_q.pop_front();
            chk(e == code, "R3 event order", code, e);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_flags[0] && !prev_evt[0]) observe(1);
            if (ctrl_start) begin
                observe(2);
                chk(ctrl_pause_time == exp_ptv, "R3 pause time", ctrl_pause_time, exp_ptv);
            end
            if (evt_flags[1] && !prev_evt[1]) observe(3);
        end
        prev_evt = evt_flags;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: request a pause and push the expected event sequence
    task automatic run_pause();
        int guard;
        exp_q.push_back(1);
        exp_q.push_back(2);
        exp_q.push_back(3);
        pause_set = 1; tick(1); pause_set = 0;
        guard = 0;
        while (!ctrl_start && guard < 20) begin tick(1); guard++; end
        chk(guard < 20, "R5 control frame commanded", guard, 0);
        tick(2);
        tx_eof = 1; tick(1); tx_eof = 0;
        tick(1);
    endtask

    task automatic clear_evts();
        evt_clr = 2'b11; tick(1); evt_clr = 0;
    endtask

    task automatic rx_pause(input logic [15:0] q);
        rx_pause_valid = 1; rx_pause_quanta = q; tick(1);
        rx_pause_valid = 0; tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        chk(data_allow == 1, "R1 reset allow", data_allow, 1);
        chk(pause_req == 0 && rx_paused == 0, "R6 reset status", {pause_req, rx_paused}, 0);
        chk(evt_flags == 0 && ctrl_start == 0, "R10 reset events", evt_flags, 0);

        // R1..R4 with a frame in flight
        tx_busy = 1;
        exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
        pause_set = 1; tick(1); pause_set = 0;
        chk(pause_req == 1, "R1 request bit", pause_req, 1);
        chk(data_allow == 0, "R1 data blocked", data_allow, 0);
        tick(4);
        chk(ctrl_start == 0, "R1 no frame while busy", ctrl_start, 0);
        chk(evt_flags[0] == 0, "R2 no stop while busy", evt_flags[0], 0);
        tx_busy = 0; tick(1);
        chk(evt_flags[0] == 1, "R2 stop complete", evt_flags[0], 1);
        chk(ctrl_start == 1, "R3 start pulse", ctrl_start, 1);
        tick(1);
        chk(ctrl_start == 0, "R3 single cycle", ctrl_start, 0);
        chk(data_allow == 0, "R4 held until sent", data_allow, 0);
        tx_eof = 1; tick(1); tx_eof = 0;
        chk(evt_flags[1] == 1, "R4 sent event", evt_flags[1], 1);
        chk(pause_req == 0, "R4 request cleared", pause_req, 0);
        chk(data_allow == 1, "R4 data resumes", data_allow, 1);
        evt_clr = 2'b01; tick(1); evt_clr = 0;
        chk(evt_flags == 2'b10, "R10 clear one bit", evt_flags, 2);
        evt_clr = 2'b10; tick(1); evt_clr = 0;
        chk(evt_flags == 2'b00, "R10 clear other bit", evt_flags, 0);

        // R6 gigabit: 2 quanta = 128 cycles
        speed_sel = 2'b10;
        rx_pause_valid = 1; rx_pause_quanta = 2; tick(1); rx_pause_valid = 0; tick(1);
        chk(rx_paused == 1 && data_allow == 0, "R6 pause starts", rx_paused, 1);
        tick(126);
        chk(rx_paused == 1, "R6 gig last cycle", rx_paused, 1);
        tick(1);
        chk(rx_paused == 0 && data_allow == 1, "R6 gig expiry", rx_paused, 0);

        // R6 100 Mb/s: 1 quantum = 640 cycles
        speed_sel = 2'b01;
        rx_pause(1);
        tick(638);
        chk(rx_paused == 1, "R6 100M last cycle", rx_paused, 1);
        tick(1);
        chk(rx_paused == 0, "R6 100M expiry", rx_paused, 0);

        // R6 10 Mb/s: 1 quantum = 6400 cycles
        speed_sel = 2'b00;
        rx_pause(1);
        tick(6398);
        chk(rx_paused == 1, "R6 10M last cycle", rx_paused, 1);
        tick(1);
        chk(rx_paused == 0, "R6 10M expiry", rx_paused, 0);

        // R8 reload: 4 quanta, after 50 cycles reload to 1 quantum (64)
        speed_sel = 2'b10;
        rx_pause(4);
        tick(49);
        rx_pause(1);
        tick(62);
        chk(rx_paused == 1, "R8 reloaded last cycle", rx_paused, 1);
        tick(1);
        chk(rx_paused == 0, "R8 reloaded expiry", rx_paused, 0);

        // R5 pause frame under a received pause, R9 zero quanta
        rx_pause(20);
        exp_ptv = 16'h00A5; ptv_value = 16'h00A5;
        run_pause();
        chk(rx_paused == 1 && data_allow == 0, "R5 still rx paused", data_allow, 0);
        chk(pause_req == 0, "R5 request cleared", pause_req, 1'b0);
        clear_evts();
        rx_pause_valid = 1; rx_pause_quanta = 0; tick(1); rx_pause_valid = 0;
        chk(rx_paused == 0, "R9 zero quanta", rx_paused, 0);

        // R11 graceful stop, R5 pause frame under it
        gts_req = 1; tick(1);
        chk(data_allow == 0, "R11 gts holds data", data_allow, 0);
        exp_ptv = 16'hBEEF; ptv_value = 16'hBEEF;
        run_pause();
        chk(data_allow == 0, "R11 still held", data_allow, 0);
        clear_evts();
        gts_req = 0; tick(1);
        chk(data_allow == 1, "R11 release", data_allow, 1);

        // R7 backpressure
        bp_enable = 1; half_duplex = 1; speed_sel = 2'b01; tick(1);
        chk(carrier_force == 1, "R7 bp on 100M", carrier_force, 1);
        tick(20);
        chk(carrier_force == 1, "R7 bp persists", carrier_force, 1);
        speed_sel = 2'b10; tick(1);
        chk(carrier_force == 0, "R7 bp off at gig", carrier_force, 0);
        speed_sel = 2'b00; half_duplex = 0; tick(1);
        chk(carrier_force == 0, "R7 bp off full duplex", carrier_force, 0);
        half_duplex = 1; tick(1);
        chk(carrier_force == 1, "R7 bp on 10M", carrier_force, 1);
        bp_enable = 0; tick(1);
        chk(carrier_force == 0, "R7 bp cleared", carrier_force, 0);

        tick(3);
        chk(exp_q.size() == 0, "R3 all events seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule